// File: doc/BRIEF.md
# One-Time-Programmable Fuse Register Front-End

This block is the bus-facing side of a fuse controller. It decodes a 32-bit register bus into a control word with bit-set and bit-clear aliases, a timing word, four data words and a window of shadow words. The shadow words mirror an internal model of the fuse array. The shadow copy is filled by a word-by-word walk that runs after reset and whenever software asks for a reload. A fuse program request goes through only when software has first written a key into the upper half of the control word and then writes data word 0. On an accepted request the target word address and the data are captured. They are then offered to an external programming sequencer, which accepts the offer and later reports completion.

Protection works per word and takes its lock bits from input vectors. A program request or a shadow write aimed at a write-locked word sets a sticky error flag. A shadow read of a read-locked word returns a poison pattern and also sets that flag. While the flag is set, the block refuses new program, reload and shadow-write requests, and every shadow read returns the poison pattern. Software clears the flag through the clear alias.

Reads are answered one cycle after the request, with `bus_rvalid` high for one cycle; the bus never stalls. The program offer follows valid/ready rules: once `prog_valid` rises, `prog_valid`, `prog_addr` and `prog_data` hold steady until the cycle in which `prog_ready` is sampled high. After that the block waits for a one-cycle `prog_done` pulse. The sequencer may hold `prog_ready` low for as long as it needs.

Top module: `fuse_regfront`

## Requirements
- R1: After reset, the block walks every shadow word from the fuse model. During the walk the control word reads 0x0000_0500 (busy bit 8 and reload bit 10 set). The walk lasts NWORDS cycles. After it, the control word reads 0 and every shadow word reads 0.
- R2: The register offsets are as follows:
  - control: 0x000
  - set alias: 0x004
  - clear alias: 0x008
  - timing: 0x010
  - data words 0 to 3: 0x020, 0x030, 0x040, 0x050
  - shadow word i: 0x400 + 0x10*i

  Read data appears together with `bus_rvalid` one cycle after the request. Both aliases read back the control word.
- R3: The control word layout is:
  - bits [6:0]: word address
  - bit 8: busy
  - bit 9: error
  - bit 10: reload
  - bits [31:16]: read 0x3E77 while a key is held, else 0

  A write to the set alias ORs its address bits into the address field. A write to the clear alias clears the address bits where the written value has ones. Any nonzero bit in [31:16] written to the clear alias drops a held key.
- R4: A data word 0 write without a held key starts nothing. `prog_valid` stays low and busy stays 0.
- R5: Writing data word 0 while the block holds a key, is idle and has no error raises busy and `prog_valid` in the next cycle. At the same time `prog_addr` takes the control address and `prog_data` takes the written data. Any data word 0 write made while the key is held consumes the key, so the next request needs a new key.
- R6: Once a request is accepted, later writes to the address field do not change `prog_addr`. Data word writes are ignored while busy.
- R7: `prog_valid` holds until `prog_ready` is sampled high. Busy clears at the edge where `prog_done` is sampled. The programmed data is ORed into the fuse model word.
- R8: A program request that targets a write-locked word, or an address at or above NWORDS, never raises `prog_valid`, leaves busy at 0 and sets error.
- R9: A shadow read of a read-locked word returns 0xBADABADA and sets error.
- R10: While error is set, the block refuses program requests, reload requests and shadow writes, and shadow reads return 0xBADABADA. Writing bit 9 to the clear alias clears error.
- R11: Writing bit 10 through the control word or the set alias while idle and error-free starts a reload. The reload sets busy and reload for NWORDS cycles and then copies the fuse model, including programmed words, over the shadows.
- R12: A shadow write to an unlocked word lands when no reload is running. A shadow write during a reload, or to a write-locked word, sets error and leaves the word unchanged.
- R13: The timing word is read/write and drives `timing_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read) |
| bus_rdata | output | 32 | Read data |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |
| timing_cfg | output | 32 | Timing word to the sequencer |
| prog_valid | output | 1 | Program offer valid |
| prog_ready | input | 1 | Sequencer accepts offer |
| prog_addr | output | 7 | Captured target word |
| prog_data | output | 32 | Captured program data |
| prog_done | input | 1 | Sequencer finished programming |

## Verification
Any lost or stuck state in the busy, key or error flags shows up in the control word, which can be read back one cycle after any access. A wrong address capture shows up directly on `prog_addr` in the cycle after launch and stays visible for the whole offer. Corruption in the fuse model or in the reload walker cannot be seen until the next reload ends, and then shows as a wrong shadow word, so the bench reads shadows only after reloads have finished and after programming cycles.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int          BUS_AW     = 12;
  localparam int          WADDR_W    = 7;
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_SET    = 12'h004;
  localparam logic [11:0] OFS_CLR    = 12'h008;
  localparam logic [11:0] OFS_TIME   = 12'h010;
  localparam logic [11:0] OFS_DATA0  = 12'h020;
  localparam logic [11:0] OFS_DSTEP  = 12'h010;
  localparam logic [11:0] OFS_SHADOW = 12'h400;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] POISON     = 32'hBADABADA;
  localparam int          BIT_BUSY   = 8;
  localparam int          BIT_ERR    = 9;
  localparam int          BIT_RELOAD = 10;

  typedef enum logic [1:0] {PG_IDLE, PG_OFFER, PG_WAIT} pg_state_e;
endpackage

// File: rtl/fuse_addr_decode.sv
module fuse_addr_decode
  import fuse_pkg::*;
#(
  parameter int NWORDS = 64,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_set,
  output logic              hit_clr,
  output logic              hit_time,
  output logic [3:0]        hit_data,
  output logic              hit_sh,
  output logic [IW-1:0]     sh_idx
);
  localparam logic [7:0] NW8 = 8'(NWORDS);

  logic [BUS_AW-1:0] sh_off;

  assign hit_ctrl = (addr == OFS_CTRL);
  assign hit_set  = (addr == OFS_SET);
  assign hit_clr  = (addr == OFS_CLR);
  assign hit_time = (addr == OFS_TIME);

  for (genvar k = 0; k < 4; k++) begin : g_data_hit
    assign hit_data[k] = (addr == OFS_DATA0 + OFS_DSTEP * 12'(k));
  end

  assign sh_off = addr - OFS_SHADOW;
  assign hit_sh = (addr >= OFS_SHADOW) && (sh_off[3:0] == 4'h0) &&
                  (sh_off[11:4] < NW8);
  assign sh_idx = sh_off[IW+3:4];
endmodule

// File: rtl/fuse_ctrl_regs.sv
module fuse_ctrl_regs
  import fuse_pkg::*;
#(
  parameter int NWORDS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic               wr_time,
  input  logic [3:0]         wr_data,
  input  logic [31:0]        wdata,
  input  logic               err_set_in,
  input  logic               reload_active,
  input  logic [NWORDS-1:0]  wr_lock,
  output logic [31:0]        ctrl_word,
  output logic [31:0]        time_q,
  output logic [3:0][31:0]   data_q,
  output logic               err_q,
  output logic               busy_all,
  output logic               reload_start,
  output logic               prog_valid,
  input  logic               prog_ready,
  output logic [WADDR_W-1:0] prog_addr,
  output logic [31:0]        prog_data,
  input  logic               prog_done,
  output logic               commit
);
  localparam logic [7:0] NW8 = 8'(NWORDS);

  pg_state_e          pg_st;
  logic               armed_q;
  logic [WADDR_W-1:0] addr_q;
  logic               lock_hit;
  logic               key_ok;
  logic               try_launch;
  logic               launch_ok;
  logic               launch_bad;
  logic               pg_busy;

  // Write lock of the word named by the address field; out-of-range counts as locked.
  always_comb begin
    lock_hit = ({1'b0, addr_q} >= NW8);
    for (int i = 0; i < NWORDS; i++) begin
      if ({1'b0, addr_q} == 8'(i)) lock_hit = wr_lock[i];
    end
  end

  assign pg_busy      = (pg_st != PG_IDLE);
  assign busy_all     = pg_busy | reload_active;
  assign key_ok       = (wdata[31:16] == UNLOCK_KEY);
  assign try_launch   = wr_data[0] & armed_q & ~busy_all;
  assign launch_ok    = try_launch & ~err_q & ~lock_hit;
  assign launch_bad   = try_launch & (err_q | lock_hit);
  assign reload_start = (wr_ctrl | wr_set) & wdata[BIT_RELOAD] & ~busy_all & ~err_q;
  assign prog_valid   = (pg_st == PG_OFFER);
  assign commit       = (pg_st == PG_WAIT) & prog_done;

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[WADDR_W-1:0] = addr_q;
    ctrl_word[BIT_BUSY]   = busy_all;
    ctrl_word[BIT_ERR]    = err_q;
    ctrl_word[BIT_RELOAD] = reload_active;
    ctrl_word[31:16]      = armed_q ? UNLOCK_KEY : 16'h0;
  end

  // Address field and key
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        addr_q  <= wdata[WADDR_W-1:0];
        armed_q <= key_ok;
      end else if (wr_set) begin
        addr_q <= addr_q | wdata[WADDR_W-1:0];
        if (key_ok) armed_q <= 1'b1;
      end else if (wr_clr) begin
        addr_q <= addr_q & ~wdata[WADDR_W-1:0];
        if (|wdata[31:16]) armed_q <= 1'b0;
      end else if (try_launch) begin
        armed_q <= 1'b0;
      end
    end
  end

  // Sticky error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (err_set_in | launch_bad) err_q <= 1'b1;
    else if (wr_clr & wdata[BIT_ERR]) err_q <= 1'b0;
  end

  // Timing and data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_time) time_q <= wdata;
      for (int k = 0; k < 4; k++) begin
        if (wr_data[k] && !busy_all) data_q[k] <= wdata;
      end
    end
  end

  // Program offer and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_st     <= PG_IDLE;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      unique case (pg_st)
        PG_IDLE: if (launch_ok) begin
          pg_st     <= PG_OFFER;
          prog_addr <= addr_q;
          prog_data <= wdata;
        end
        PG_OFFER: if (prog_ready) pg_st <= PG_WAIT;
        PG_WAIT:  if (prog_done)  pg_st <= PG_IDLE;
        default:  pg_st <= PG_IDLE;
      endcase
    end
  end

  a_r7_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid && !prog_ready |=> prog_valid && $stable(prog_addr) && $stable(prog_data));

  a_r6_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pg_busy |=> !pg_busy || ($stable(prog_addr) && $stable(prog_data)));

  a_r8_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    try_launch && lock_hit |=> !prog_valid && err_q);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr_clr && wdata[BIT_ERR]) |=> err_q);

  a_r5_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    try_launch |=> !armed_q);

  a_r6_busy_offer: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> ctrl_word[BIT_BUSY]);
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fuse_pkg::*;
#(
  parameter int NWORDS = 64,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sh_rd,
  input  logic               sh_wr,
  input  logic [IW-1:0]      sh_idx,
  input  logic [31:0]        wdata,
  input  logic [NWORDS-1:0]  rd_lock,
  input  logic [NWORDS-1:0]  wr_lock,
  input  logic               err_q,
  input  logic               reload_start,
  input  logic               commit,
  input  logic [WADDR_W-1:0] commit_addr,
  input  logic [31:0]        commit_data,
  output logic [31:0]        sh_rdata,
  output logic               reload_active,
  output logic               err_set
);
  localparam logic [7:0]    NW8  = 8'(NWORDS);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

  logic [31:0]   fuse_q   [NWORDS];
  logic [31:0]   shadow_q [NWORDS];
  logic [IW-1:0] walk_idx;
  logic          bad_wr;
  logic          bad_rd;

  assign bad_rd   = sh_rd & ~err_q & rd_lock[sh_idx];
  assign bad_wr   = sh_wr & ~err_q & (reload_active | wr_lock[sh_idx]);
  assign err_set  = bad_rd | bad_wr;
  assign sh_rdata = (err_q | rd_lock[sh_idx]) ? POISON : shadow_q[sh_idx];

  // Fuse model: programmed ones accumulate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) fuse_q[i] <= '0;
    end else if (commit && ({1'b0, commit_addr} < NW8)) begin
      fuse_q[commit_addr[IW-1:0]] <= fuse_q[commit_addr[IW-1:0]] | commit_data;
    end
  end

  // Reload walker, started by reset and by request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_active <= 1'b1;
      walk_idx      <= '0;
    end else if (reload_active) begin
      walk_idx <= walk_idx + 1'b1;
      if (walk_idx == LAST) reload_active <= 1'b0;
    end else if (reload_start) begin
      reload_active <= 1'b1;
      walk_idx      <= '0;
    end
  end

  // Shadow words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow_q[i] <= '0;
    end else if (reload_active) begin
      shadow_q[walk_idx] <= fuse_q[walk_idx];
    end else if (sh_wr && !err_q && !wr_lock[sh_idx]) begin
      shadow_q[sh_idx] <= wdata;
    end
  end

  a_r11_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    reload_active && (walk_idx == LAST) |=> !reload_active);

  a_r12_no_start_midwalk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_active && !(walk_idx == LAST) |=> reload_active && (walk_idx != '0));
endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
  import fuse_pkg::*;
#(
  parameter int NWORDS = 64,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               bus_rvalid,
  output logic [31:0]        bus_rdata,
  input  logic [NWORDS-1:0]  rd_lock,
  input  logic [NWORDS-1:0]  wr_lock,
  output logic [31:0]        timing_cfg,
  output logic               prog_valid,
  input  logic               prog_ready,
  output logic [6:0]         prog_addr,
  output logic [31:0]        prog_data,
  input  logic               prog_done
);
  logic            hit_ctrl, hit_set, hit_clr, hit_time, hit_sh;
  logic [3:0]      hit_data;
  logic [IW-1:0]   sh_idx;
  logic            wr, rd;
  logic [31:0]     ctrl_word, time_q, sh_rdata, rd_next;
  logic [3:0][31:0] data_q;
  logic            err_q, busy_all, reload_start, reload_active, err_set, commit;

  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  fuse_addr_decode #(.NWORDS(NWORDS)) u_dec (
    .addr     (bus_addr),
    .hit_ctrl (hit_ctrl),
    .hit_set  (hit_set),
    .hit_clr  (hit_clr),
    .hit_time (hit_time),
    .hit_data (hit_data),
    .hit_sh   (hit_sh),
    .sh_idx   (sh_idx)
  );

  fuse_ctrl_regs #(.NWORDS(NWORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctrl       (wr & hit_ctrl),
    .wr_set        (wr & hit_set),
    .wr_clr        (wr & hit_clr),
    .wr_time       (wr & hit_time),
    .wr_data       ({4{wr}} & hit_data),
    .wdata         (bus_wdata),
    .err_set_in    (err_set),
    .reload_active (reload_active),
    .wr_lock       (wr_lock),
    .ctrl_word     (ctrl_word),
    .time_q        (time_q),
    .data_q        (data_q),
    .err_q         (err_q),
    .busy_all      (busy_all),
    .reload_start  (reload_start),
    .prog_valid    (prog_valid),
    .prog_ready    (prog_ready),
    .prog_addr     (prog_addr),
    .prog_data     (prog_data),
    .prog_done     (prog_done),
    .commit        (commit)
  );

  fuse_shadow_bank #(.NWORDS(NWORDS)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .sh_rd         (rd & hit_sh),
    .sh_wr         (wr & hit_sh),
    .sh_idx        (sh_idx),
    .wdata         (bus_wdata),
    .rd_lock       (rd_lock),
    .wr_lock       (wr_lock),
    .err_q         (err_q),
    .reload_start  (reload_start),
    .commit        (commit),
    .commit_addr   (prog_addr),
    .commit_data   (prog_data),
    .sh_rdata      (sh_rdata),
    .reload_active (reload_active),
    .err_set       (err_set)
  );

  assign timing_cfg = time_q;

  always_comb begin
    rd_next = '0;
    if (hit_ctrl | hit_set | hit_clr) rd_next = ctrl_word;
    else if (hit_time)                rd_next = time_q;
    else if (hit_sh)                  rd_next = sh_rdata;
    for (int k = 0; k < 4; k++) begin
      if (hit_data[k]) rd_next = data_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_next;
    end
  end

  a_r9_locked_read_poison: assert property (@(posedge clk) disable iff (!rst_n)
    rd && hit_sh && rd_lock[sh_idx] |=> bus_rvalid && (bus_rdata == POISON) && err_q);

  a_r2_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  a_r11_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reload_active |-> busy_all && !prog_valid);
endmodule

// File: tb/sim_fuse_regfront.sv
module sim_fuse_regfront;
  localparam int  NW     = 16;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NW-1:0] rd_lock = '0, wr_lock = '0;
  logic [31:0]   timing_cfg;
  logic          prog_valid;
  logic          prog_ready = 1'b0;
  logic [6:0]    prog_addr;
  logic [31:0]   prog_data;
  logic          prog_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  fuse_regfront #(.NWORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .rd_lock(rd_lock), .wr_lock(wr_lock),
    .timing_cfg(timing_cfg), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  // R2/R3/R4/R12/R13 register walk
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 12'h010, 32'h0000_1234, 32'h0},           // R13
    '{1'b0, 12'h010, 32'h0,         32'h0000_1234},   // R13
    '{1'b1, 12'h030, 32'hA5A5_A5A5, 32'h0},           // R2
    '{1'b1, 12'h040, 32'h00C0_FFEE, 32'h0},
    '{1'b1, 12'h050, 32'h8000_0001, 32'h0},
    '{1'b0, 12'h030, 32'h0,         32'hA5A5_A5A5},
    '{1'b0, 12'h040, 32'h0,         32'h00C0_FFEE},
    '{1'b0, 12'h050, 32'h0,         32'h8000_0001},
    '{1'b1, 12'h000, 32'h0000_0015, 32'h0},           // R3
    '{1'b0, 12'h000, 32'h0,         32'h0000_0015},
    '{1'b1, 12'h004, 32'h0000_0060, 32'h0},           // R3 set alias
    '{1'b0, 12'h004, 32'h0,         32'h0000_0075},
    '{1'b1, 12'h008, 32'h0000_0011, 32'h0},           // R3 clear alias
    '{1'b0, 12'h008, 32'h0,         32'h0000_0064},
    '{1'b1, 12'h000, 32'h3E77_0003, 32'h0},           // R3 key readback
    '{1'b0, 12'h000, 32'h0,         32'h3E77_0003},
    '{1'b1, 12'h008, 32'hFFFF_0000, 32'h0},
    '{1'b0, 12'h000, 32'h0,         32'h0000_0003},
    '{1'b1, 12'h020, 32'h0000_00F0, 32'h0},           // R4 no key
    '{1'b0, 12'h000, 32'h0,         32'h0000_0003},
    '{1'b0, 12'h020, 32'h0,         32'h0000_00F0},
    '{1'b1, 12'h410, 32'hCAFE_0001, 32'h0},           // R12 shadow write
    '{1'b0, 12'h410, 32'h0,         32'hCAFE_0001},
    '{1'b0, 12'h460, 32'h0,         32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rvalid ? bus_rdata : 32'hDEAD_0000, exp);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ready;
    prog_ready = 1'b1; @(negedge clk); prog_ready = 1'b0;
  endtask

  task automatic pulse_done;
    prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: load walk right after reset
    rchk("R1 ctrl during walk", 12'h000, 32'h0000_0500);
    idle(NW + 4);
    rchk("R1 ctrl after walk", 12'h000, 32'h0);
    rchk("R1 shadow0 after reset", 12'h400, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].a, TBL[i].d);
      else rchk($sformatf("table[%0d]", i), TBL[i].a, TBL[i].e);
    end
    chk("R13 timing_cfg", timing_cfg, 32'h0000_1234);
    chk("R4 no offer", {31'b0, prog_valid}, 32'h0);

    // R5: launch
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_0081);
    chk("R5 prog_valid", {31'b0, prog_valid}, 32'h1);
    chk("R5 prog_addr", {25'b0, prog_addr}, 32'h5);
    chk("R5 prog_data", prog_data, 32'h0000_0081);
    rchk("R5 busy, key cleared", 12'h000, 32'h0000_0105);
    // R6: snapshot and data protection
    wr(12'h000, 32'h0000_0007);
    chk("R6 prog_addr kept", {25'b0, prog_addr}, 32'h5);
    wr(12'h020, 32'h1234_5678);
    rchk("R6 data0 ignored while busy", 12'h020, 32'h0000_0081);
    // R7: offer holds, then handshake
    idle(3);
    chk("R7 offer held", {31'b0, prog_valid}, 32'h1);
    pulse_ready;
    chk("R7 offer taken", {31'b0, prog_valid}, 32'h0);
    rchk("R7 busy until done", 12'h000, 32'h0000_0107);
    pulse_done;
    rchk("R7 idle after done", 12'h000, 32'h0000_0007);
    // R5: key consumed
    wr(12'h020, 32'h0000_0001);
    chk("R5 no relaunch without key", {31'b0, prog_valid}, 32'h0);
    rchk("R5 still idle", 12'h000, 32'h0000_0007);
    // second program into word 5 for the OR check
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_0100);
    pulse_ready;
    pulse_done;
    // R11: reload
    wr(12'h004, 32'h0000_0400);
    rchk("R11 reload running", 12'h000, 32'h0000_0505);
    idle(NW + 4);
    rchk("R11 reload ended", 12'h000, 32'h0000_0005);
    rchk("R7 R11 fuse OR in shadow", 12'h450, 32'h0000_0181);
    rchk("R11 shadow1 overwritten", 12'h410, 32'h0);

    // R8: write-locked target
    wr_lock = NW'(1) << 3;
    wr(12'h000, 32'h3E77_0003);
    wr(12'h020, 32'h0000_00FF);
    chk("R8 locked no offer", {31'b0, prog_valid}, 32'h0);
    rchk("R8 error no busy", 12'h000, 32'h0000_0203);

    // R10: error gating
    wr(12'h000, 32'h3E77_0004);
    wr(12'h020, 32'h0000_0001);
    chk("R10 program refused", {31'b0, prog_valid}, 32'h0);
    rchk("R10 ctrl", 12'h000, 32'h0000_0204);
    wr(12'h004, 32'h0000_0400);
    rchk("R10 reload refused", 12'h000, 32'h0000_0204);
    rchk("R10 read poison", 12'h400, 32'hBADA_BADA);
    wr(12'h420, 32'h0000_0055);
    wr(12'h008, 32'h0000_0200);
    rchk("R10 error cleared", 12'h000, 32'h0000_0004);
    rchk("R10 shadow write refused", 12'h420, 32'h0);

    // R8: out-of-range target
    wr(12'h000, 32'h3E77_0010);
    wr(12'h020, 32'h0000_0001);
    chk("R8 range no offer", {31'b0, prog_valid}, 32'h0);
    rchk("R8 range error", 12'h000, 32'h0000_0210);
    wr(12'h008, 32'h0000_0200);

    // R9: read lock
    rd_lock = NW'(1) << 2;
    rchk("R9 poison", 12'h420, 32'hBADA_BADA);
    rchk("R9 error set", 12'h000, 32'h0000_0210);
    wr(12'h008, 32'h0000_0200);
    rd_lock = '0;
    rchk("R9 unlocked read", 12'h420, 32'h0);

    // R12: write-locked shadow, then write during reload
    wr(12'h430, 32'h0000_0077);
    rchk("R12 locked write error", 12'h000, 32'h0000_0210);
    wr(12'h008, 32'h0000_0200);
    rchk("R12 locked word unchanged", 12'h430, 32'h0);
    wr(12'h004, 32'h0000_0400);
    wr(12'h440, 32'h0000_0099);
    rchk("R12 write during reload error", 12'h000, 32'h0000_0710);
    idle(NW + 4);
    wr(12'h008, 32'h0000_0200);
    rchk("R12 word after reload", 12'h440, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule